// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes 64-bit send commands and turns each one into a single 32-bit store into a register of a chosen target core. A command names the target core, carries a 32-bit payload and holds a four-bit keep mask with one bit per byte lane. A set bit protects the matching byte of the value already in the target register. If any keep bit is set, the block first reads the target register over a read request/response pair and merges the old bytes with the payload before it writes. If no keep bit is set, it writes the payload straight away and issues no read.

There are two command kinds. A mailbox send picks one of eight mailbox words at a fixed base address inside the target's register space. An any-register send carries a full 16-bit register address. Commands count only when they arrive as full 64-bit accesses. While a command is in flight the block reports busy and drops any further command.

The controller is a three-state machine. IDLE waits for a command. READ holds the read request until the response arrives. WRITE drives one write pulse. The transitions are: IDLE to READ on an accepted command with a non-zero keep mask; IDLE to WRITE on an accepted command with a zero keep mask; READ to WRITE when the read response arrives; READ to READ while it has not arrived; WRITE to IDLE always; IDLE to IDLE when no command is accepted.

Top module: `mbox_rmw_writer`

## Requirements
- R1: The target core index driven on `tgt_core` is command bits 25:16 (10 bits).
- R2: When command bits 30:27 are all zero, no read is issued. `wr_req` rises in the cycle after the command is accepted, and `wr_data` equals command bits 63:32 unchanged.
- R3: When any of command bits 30:27 is set, `rd_req` rises in the cycle after acceptance. It stays high, with `tgt_core` and `tgt_addr` stable, until a cycle in which `rd_ack` is high. `wr_req` follows in the next cycle.
- R4: Command bit 27+i keeps byte lane i (bits 8i+7:8i). The written value is (old AND kept-lane bytes) OR (payload AND NOT kept-lane bytes), where old is `rd_data` sampled with `rd_ack`.
- R5: When `cmd_is_any` is 0 (mailbox send), `tgt_addr` is 0x1020 + (command AND 0x1C). All other command bits 15:0 have no effect on the address.
- R6: When `cmd_is_any` is 1 (any-register send), `tgt_addr` is command bits 15:0.
- R7: A command presented with `cmd_full` low is ignored: busy stays low and no read or write follows.
- R8: While `busy` is high, incoming commands are ignored. The write in progress keeps the address and data of the command that started it.
- R9: Each accepted command produces exactly one `wr_req` pulse, one cycle wide. `busy` drops in the cycle after that pulse.
- R10: After reset, `busy`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A send command is present |
| cmd_is_any | input | 1 | 0 = mailbox send, 1 = any-register send |
| cmd_full | input | 1 | The access is a full 64-bit write |
| cmd_word | input | 64 | Command word |
| busy | output | 1 | A command is in flight; new commands are dropped |
| tgt_core | output | 10 | Target core index |
| tgt_addr | output | 16 | Target register address |
| rd_req | output | 1 | Read request to the target register |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| wr_req | output | 1 | Write strobe, one cycle |
| wr_data | output | 32 | Merged data to write |

## Verification
The bench builds the block with the default mailbox base of 0x1020. With that base, the highest and lowest mailbox slots land on fixed, predictable addresses. The vectors reach core indices 0 and 0x3FF, any-register addresses 0x0000 and 0xFFFC, and keep masks from none through single lanes to all four lanes. The directed part delays read responses by several cycles and presents commands while busy and as narrow accesses.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
    localparam int CMD_W    = 64;
    localparam int DATA_W   = 32;
    localparam int CORE_W   = 10;
    localparam int ADDR_W   = 16;
    localparam int LANES    = DATA_W / 8;
    localparam int CORE_LSB = 16;
    localparam int KEEP_LSB = 27;
    localparam int PAY_LSB  = 32;
    localparam logic [ADDR_W-1:0] SLOT_MASK = 16'h001C;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } mbw_state_e;

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  keep;
        logic [DATA_W-1:0] payload;
    } mbw_req_t;
endpackage

// File: rtl/mbw_decode.sv
module mbw_decode
    import mbw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020
) (
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             cmd_is_any,
    output mbw_req_t         req
);
    always_comb begin
        req.core    = cmd_word[CORE_LSB +: CORE_W];
        req.keep    = cmd_word[KEEP_LSB +: LANES];
        req.payload = cmd_word[PAY_LSB +: DATA_W];
        if (cmd_is_any) begin
            req.addr = cmd_word[ADDR_W-1:0];
        end else begin
            req.addr = MBOX_BASE + (cmd_word[ADDR_W-1:0] & SLOT_MASK);
        end
    end
endmodule

// File: rtl/mbw_merge.sv
module mbw_merge #(
    parameter int LANES = 4,
    localparam int W    = LANES * 8
) (
    input  logic [LANES-1:0] keep,
    input  logic [W-1:0]     old_val,
    input  logic [W-1:0]     new_val,
    output logic [W-1:0]     merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = keep[i] ? old_val[8*i +: 8] : new_val[8*i +: 8];
    end
endmodule

// File: rtl/mbw_ctrl.sv
module mbw_ctrl
    import mbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_read,
    input  logic rd_ack,
    output logic busy,
    output logic rd_req,
    output logic wr_req,
    output logic load_old
);
    mbw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = need_read ? ST_READ : ST_WRITE;
            end
            ST_READ: begin
                if (rd_ack) state_d = ST_WRITE;
            end
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        rd_req   = (state_q == ST_READ);
        wr_req   = (state_q == ST_WRITE);
        load_old = (state_q == ST_READ) && rd_ack;
    end
endmodule

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer
    import mbw_pkg::*;
#(
    parameter logic [15:0] MBOX_BASE = 16'h1020
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_is_any,
    input  logic        cmd_full,
    input  logic [63:0] cmd_word,
    output logic        busy,
    output logic [9:0]  tgt_core,
    output logic [15:0] tgt_addr,
    output logic        rd_req,
    input  logic        rd_ack,
    input  logic [31:0] rd_data,
    output logic        wr_req,
    output logic [31:0] wr_data
);
    mbw_req_t          dec_req;
    mbw_req_t          req_q;
    logic [DATA_W-1:0] old_q;
    logic              accept;
    logic              load_old;

    mbw_decode #(.MBOX_BASE(MBOX_BASE)) u_decode (
        .cmd_word   (cmd_word),
        .cmd_is_any (cmd_is_any),
        .req        (dec_req)
    );

    assign accept = cmd_valid && cmd_full && !busy;

    mbw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .need_read (|dec_req.keep),
        .rd_ack    (rd_ack),
        .busy      (busy),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .load_old  (load_old)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            old_q <= '0;
        end else begin
            if (accept)   req_q <= dec_req;
            if (load_old) old_q <= rd_data;
        end
    end

    mbw_merge #(.LANES(LANES)) u_merge (
        .keep    (req_q.keep),
        .old_val (old_q),
        .new_val (req_q.payload),
        .merged  (wr_data)
    );

    assign tgt_core = req_q.core;
    assign tgt_addr = req_q.addr;
endmodule

// File: rtl/mbox_rmw_writer_chk.sv
module mbox_rmw_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_full,
    input logic [63:0] cmd_word,
    input logic        busy,
    input logic [9:0]  tgt_core,
    input logic [15:0] tgt_addr,
    input logic        rd_req,
    input logic        rd_ack,
    input logic        wr_req
);
    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_full && !busy && cmd_word[30:27] == 4'b0) |=> (wr_req && !rd_req));

    a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_full && !busy && cmd_word[30:27] != 4'b0) |=> (rd_req && !wr_req));

    a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(tgt_addr) && $stable(tgt_core)));

    a_r4_ack_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> wr_req);

    a_r7_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_full && !busy) |=> !busy);

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (!wr_req && !busy));

    a_r8_reqs_need_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> (busy && !(rd_req && wr_req)));
endmodule

bind mbox_rmw_writer mbox_rmw_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_full  (cmd_full),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .tgt_core  (tgt_core),
    .tgt_addr  (tgt_addr),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .wr_req    (wr_req)
);

// File: tb/mbox_rmw_writer_test.sv
module mbox_rmw_writer_test;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        is_any;
        logic [63:0] cmd;
        logic [31:0] old;
        logic [9:0]  core;
        logic [15:0] addr;
        logic [31:0] data;
        logic        rd;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'hDEADBEEF_03A5000C, 32'h0,         10'h3A5, 16'h102C, 32'hDEADBEEF, 1'b0},
        '{1'b0, 64'h11223344_2807001C, 32'hAABBCCDD, 10'h007, 16'h103C, 32'h11BB33DD, 1'b1},
        '{1'b1, 64'hCAFEF00D_7BFF1008, 32'h01234567, 10'h3FF, 16'h1008, 32'h01234567, 1'b1},
        '{1'b1, 64'h55667788_4000FFFC, 32'h99AABBCC, 10'h000, 16'hFFFC, 32'h99667788, 1'b1},
        '{1'b1, 64'h0F0F0F0F_02000000, 32'h0,         10'h200, 16'h0000, 32'h0F0F0F0F, 1'b0},
        '{1'b0, 64'h12345678_8001FFE3, 32'h0,         10'h001, 16'h1020, 32'h12345678, 1'b0},
        '{1'b0, 64'hA1B2C3D4_11550008, 32'h5E6F7081, 10'h155, 16'h1028, 32'hA1B270D4, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_any = 1'b0;
    logic        cmd_full = 1'b0;
    logic [63:0] cmd_word = '0;
    logic        busy;
    logic [9:0]  tgt_core;
    logic [15:0] tgt_addr;
    logic        rd_req;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_req;
    logic [31:0] wr_data;

    int checks = 0;
    int failures = 0;
    int wr_count = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_rmw_writer uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_any(cmd_is_any),
        .cmd_full(cmd_full), .cmd_word(cmd_word), .busy(busy), .tgt_core(tgt_core),
        .tgt_addr(tgt_addr), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_data(wr_data)
    );

    always @(posedge clk) if (rst_n && wr_req) wr_count++;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one vector; ack_delay idle cycles pass before the read response.
    task automatic run_vec(input vec_t v, input int ack_delay);
        int start_cnt;
        start_cnt = wr_count;
        cmd_valid = 1'b1; cmd_full = 1'b1; cmd_is_any = v.is_any; cmd_word = v.cmd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v.rd) begin
            check("R3 rd_req after accept", rd_req, 1);
            check("R3 no early write", wr_req, 0);
            check("R1 core during read", tgt_core, v.core);
            for (int k = 0; k < ack_delay; k++) begin
                @(negedge clk);
                check("R3 rd_req held", rd_req, 1);
            end
            rd_ack = 1'b1; rd_data = v.old;
            @(negedge clk);
            rd_ack = 1'b0; rd_data = '0;
        end else begin
            check("R2 no read when mask zero", rd_req, 0);
        end
        check("R9 write pulse", wr_req, 1);
        check("R1 target core", tgt_core, v.core);
        check(v.is_any ? "R6 any address" : "R5 mailbox address", tgt_addr, v.addr);
        check(v.rd ? "R4 merged data" : "R2 direct data", wr_data, v.data);
        @(negedge clk);
        check("R9 pulse ends", wr_req, 0);
        check("R9 idle after write", busy, 0);
        check("R9 single write", wr_count - start_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 busy after reset", busy, 0);
        check("R10 rd_req after reset", rd_req, 0);
        check("R10 wr_req after reset", wr_req, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i % 3);

        // R7: narrow access is dropped
        begin
            int c0;
            c0 = wr_count;
            cmd_valid = 1'b1; cmd_full = 1'b0; cmd_is_any = 1'b0; cmd_word = VECS[0].cmd;
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R7 narrow no busy", busy, 0);
            check("R7 narrow no write", wr_req, 0);
            check("R7 narrow no read", rd_req, 0);
            @(negedge clk);
            check("R7 narrow write count", wr_count - c0, 0);
        end

        // R8: command presented during a pending read is dropped
        begin
            int c0;
            c0 = wr_count;
            cmd_valid = 1'b1; cmd_full = 1'b1; cmd_is_any = VECS[1].is_any; cmd_word = VECS[1].cmd;
            @(negedge clk);
            cmd_is_any = VECS[2].is_any; cmd_word = VECS[2].cmd;
            @(negedge clk);
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R8 still reading", rd_req, 1);
            check("R8 address kept", tgt_addr, VECS[1].addr);
            rd_ack = 1'b1; rd_data = VECS[1].old;
            @(negedge clk);
            rd_ack = 1'b0;
            check("R8 write of first command", wr_data, VECS[1].data);
            check("R8 core of first command", tgt_core, VECS[1].core);
            @(negedge clk);
            @(negedge clk);
            check("R8 only one write", wr_count - c0, 1);
            check("R8 idle afterwards", busy, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule